// File: doc/BRIEF.md
# Block Transfer DMA Engine

This block copies a block of words between a single peripheral data port and consecutive memory locations without help from the processor. A host writes three configuration registers: the first memory address, the number of words and a control word. The control word selects the transfer direction and the bus-use policy. Setting its start bit launches the transfer. The engine then runs on its own until every word has been moved. At that point it raises a sticky completion flag and a single-cycle completion strobe.

The memory bus is shared with a processor. The engine asks for the bus with a request line and drives the bus only in cycles where the arbiter's grant is also high. Two policies are available. In the stealing policy the engine asks for the bus only when it has a word ready to move. It performs exactly one access and then withdraws its request for at least one cycle, so the processor can take the bus back between words. In the burst policy the engine keeps requesting from the moment the transfer starts until it completes.

The peripheral side uses a valid/ready handshake in each direction. A one-word holding register sits between the peripheral port and the memory bus. A slow peripheral or a busy bus therefore stalls the transfer without dropping or duplicating any word.

Top module: `dma_xfer_engine`

## Requirements
- R1: Register writes take effect when `cfg_we` is high at a clock edge, with `cfg_idx` selecting the target: 0 = first memory address, 1 = word count, 2 = control. Control bit 0 selects direction (0 = peripheral to memory, 1 = memory to peripheral). Control bit 1 selects policy (0 = stealing, 1 = burst). Writing control bit 2 as 1 starts a transfer using the current register contents.
- R2: A transfer of N words touches memory addresses first, first+1, ..., first+N-1 in that order. Word k of the peripheral stream maps to address first+k. No address outside that range is written.
- R3: `mem_we` or `mem_re` is high only in cycles where both `bus_req` and `bus_gnt` are high.
- R4: In the stealing policy, each grant cycle with an access moves exactly one word. `bus_req` is low in the cycle after every access.
- R5: In the burst policy, `bus_req` stays high in every cycle in which `busy` is high.
- R6: When the last word is finished, `busy` falls, `done` rises and `done_pulse` is high for exactly one cycle. `done` stays high until the next accepted start, which clears it.
- R7: A start with a word count of 0 raises `done_pulse` and `done` in the cycle after the start write. It never raises `busy` or `bus_req` and never accesses memory.
- R8: While `busy` is high, every register write is ignored, including a write with the start bit set. A later start reuses the address, count and control values held before the transfer.
- R9: Peripheral stalls lose no data. While `per_out_valid` is high and `per_out_ready` is low, `per_out_data` holds its value into the next cycle. Exactly N handshakes occur on the active peripheral side.
- R10: After reset, `busy`, `done`, `done_pulse`, `bus_req`, `mem_we`, `mem_re`, `per_in_ready` and `per_out_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register select (0 address, 1 count, 2 control) |
| cfg_wdata | input | REG_W | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| done_pulse | output | 1 | One-cycle completion strobe |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant from the arbiter |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data taken in the same cycle |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| per_in_valid | input | 1 | Peripheral-to-engine word valid |
| per_in_ready | output | 1 | Engine can accept a peripheral word |
| per_in_data | input | DATA_W | Peripheral-to-engine word |
| per_out_valid | output | 1 | Engine-to-peripheral word valid |
| per_out_ready | input | 1 | Peripheral accepts the word |
| per_out_data | output | DATA_W | Engine-to-peripheral word |

## Verification
The embedded properties assume the arbiter raises the grant only while a request is pending. They also assume memory returns read data in the same cycle as `mem_re`, and that the host writes only register indices 0 to 2. The bench arbiter registers the request: the grant follows one cycle later, and only while a modelled processor is idle, then drops a cycle after the request is withdrawn. The bench memory answers reads combinationally. Peripheral stalls, processor bus occupancy and both policies are combined across a table of transfers. Directed cases cover the empty transfer and the writes that arrive mid-transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic {
    DIR_TO_MEM  = 1'b0,
    DIR_TO_PERI = 1'b1
  } dma_dir_e;

  typedef enum logic {
    POLICY_STEAL = 1'b0,
    POLICY_BURST = 1'b1
  } dma_policy_e;

  localparam int unsigned IDX_W        = 2;
  localparam int unsigned IDX_FIRST    = 0;
  localparam int unsigned IDX_COUNT    = 1;
  localparam int unsigned IDX_CONTROL  = 2;

  localparam int unsigned CTL_DIR_BIT    = 0;
  localparam int unsigned CTL_POLICY_BIT = 1;
  localparam int unsigned CTL_GO_BIT     = 2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [CNT_W-1:0]  word_cnt_o,
  output dma_dir_e          dir_o,
  output dma_policy_e       policy_o,
  output logic              go_o
);

  logic              wr_ok;
  logic              first_en, count_en, ctl_en;
  logic [ADDR_W-1:0] first_q, first_d;
  logic [CNT_W-1:0]  count_q, count_d;
  dma_dir_e          dir_q, dir_d;
  dma_policy_e       policy_q, policy_d;

  // Writes are accepted only while idle.
  assign wr_ok    = wr_en_i && !busy_i;
  assign first_en = wr_ok && (wr_idx_i == IDX_W'(IDX_FIRST));
  assign count_en = wr_ok && (wr_idx_i == IDX_W'(IDX_COUNT));
  assign ctl_en   = wr_ok && (wr_idx_i == IDX_W'(IDX_CONTROL));

  always_comb begin
    first_d  = wr_data_i[ADDR_W-1:0];
    count_d  = wr_data_i[CNT_W-1:0];
    dir_d    = dma_dir_e'(wr_data_i[CTL_DIR_BIT]);
    policy_d = dma_policy_e'(wr_data_i[CTL_POLICY_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      count_q  <= '0;
      dir_q    <= DIR_TO_MEM;
      policy_q <= POLICY_STEAL;
    end else begin
      if (first_en) first_q <= first_d;
      if (count_en) count_q <= count_d;
      if (ctl_en) begin
        dir_q    <= dir_d;
        policy_q <= policy_d;
      end
    end
  end

  assign go_o         = ctl_en && wr_data_i[CTL_GO_BIT];
  assign first_addr_o = first_q;
  assign word_cnt_o   = count_q;
  assign dir_o        = dir_q;
  assign policy_o     = policy_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(first_q) && $stable(count_q) && $stable(dir_q) && $stable(policy_q)))
    else $error("configuration changed during a transfer"); // R8

endmodule

// File: rtl/dma_word_buf.sv
module dma_word_buf #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              drain_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q, full_d, full_en;
  logic [DATA_W-1:0] data_q;

  assign full_en = fill_i || drain_i;

  always_comb begin
    full_d = full_q;
    if (fill_i)       full_d = 1'b1;
    else if (drain_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (full_en) full_q <= full_d;
      if (fill_i)  data_q <= fill_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |-> !full_q) else $error("word written over a held word"); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> full_q) else $error("word taken from an empty holder"); // R9

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  dma_dir_e          dir_i,
  input  dma_policy_e       policy_i,
  input  logic              buf_full_i,
  input  logic              peri_xfer_i,
  input  logic              bus_gnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_pulse_o,
  output logic              bus_req_o,
  output logic              mem_acc_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              peri_open_o
);

  logic              busy_q, busy_d, busy_en;
  logic              done_q, done_d, done_en;
  logic              pulse_q, pulse_d;
  logic              gap_q, gap_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [CNT_W-1:0]  mem_left_q, mem_left_d;
  logic              mem_left_en;
  logic [CNT_W-1:0]  peri_left_q, peri_left_d;
  logic              peri_left_en;

  logic mem_pending, need_acc, req, acc, finish, empty_go;

  // Memory side wants the bus when the holder can take or give a word.
  assign mem_pending = busy_q && (mem_left_q != '0);
  assign need_acc    = mem_pending && ((dir_i == DIR_TO_PERI) ? !buf_full_i : buf_full_i);
  assign req         = busy_q && ((policy_i == POLICY_BURST) || (need_acc && !gap_q));
  assign acc         = req && bus_gnt_i && need_acc;
  assign finish      = busy_q && (mem_left_q == '0) && (peri_left_q == '0);
  assign empty_go    = go_i && (word_cnt_i == '0);

  always_comb begin
    busy_en = (go_i && !empty_go) || finish;
    busy_d  = !finish;

    done_en = go_i || finish;
    done_d  = finish || empty_go;

    pulse_d = finish || empty_go;

    gap_d   = acc && (policy_i == POLICY_STEAL);

    addr_en = go_i || acc;
    addr_d  = go_i ? first_addr_i : addr_q + ADDR_W'(1);

    mem_left_en = go_i || acc;
    mem_left_d  = go_i ? word_cnt_i : mem_left_q - CNT_W'(1);

    peri_left_en = go_i || peri_xfer_i;
    peri_left_d  = go_i ? word_cnt_i : peri_left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      pulse_q     <= 1'b0;
      gap_q       <= 1'b0;
      addr_q      <= '0;
      mem_left_q  <= '0;
      peri_left_q <= '0;
    end else begin
      pulse_q <= pulse_d;
      gap_q   <= gap_d;
      if (busy_en)      busy_q      <= busy_d;
      if (done_en)      done_q      <= done_d;
      if (addr_en)      addr_q      <= addr_d;
      if (mem_left_en)  mem_left_q  <= mem_left_d;
      if (peri_left_en) peri_left_q <= peri_left_d;
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign done_pulse_o = pulse_q;
  assign bus_req_o    = req;
  assign mem_acc_o    = acc;
  assign mem_addr_o   = addr_q;
  assign peri_open_o  = busy_q && (peri_left_q != '0);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (addr_q == $past(addr_q) + ADDR_W'(1)))
    else $error("address did not advance by one"); // R2

  AST_STEAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (policy_i == POLICY_STEAL)) |=> !bus_req_o)
    else $error("request not withdrawn after a stolen cycle"); // R4

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (policy_i == POLICY_BURST) && !finish) |=> bus_req_o)
    else $error("burst released the bus early"); // R5

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q) else $error("completion strobe longer than one cycle"); // R6

  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (done_q && !busy_q)) else $error("strobe without idle and done"); // R6

  AST_COUNT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((dir_i == DIR_TO_PERI) ? (peri_left_q >= mem_left_q)
                                       : (mem_left_q >= peri_left_q)))
    else $error("one side ran ahead of the other"); // R9

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_pulse,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [DATA_W-1:0] per_out_data
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic [ADDR_W-1:0] first_addr;
  logic [CNT_W-1:0]  word_cnt;
  dma_dir_e          dir;
  dma_policy_e       policy;
  logic              go;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              mem_acc, peri_open;
  logic              to_peri, in_fire, out_fire;
  logic              buf_fill, buf_drain;
  logic [DATA_W-1:0] buf_fill_data;

  dma_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .REG_W  (REG_W)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_ns),
    .busy_i       (busy),
    .wr_en_i      (cfg_we),
    .wr_idx_i     (cfg_idx),
    .wr_data_i    (cfg_wdata),
    .first_addr_o (first_addr),
    .word_cnt_o   (word_cnt),
    .dir_o        (dir),
    .policy_o     (policy),
    .go_o         (go)
  );

  dma_bus_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_ns),
    .go_i         (go),
    .first_addr_i (first_addr),
    .word_cnt_i   (word_cnt),
    .dir_i        (dir),
    .policy_i     (policy),
    .buf_full_i   (buf_full),
    .peri_xfer_i  (in_fire || out_fire),
    .bus_gnt_i    (bus_gnt),
    .busy_o       (busy),
    .done_o       (done),
    .done_pulse_o (done_pulse),
    .bus_req_o    (bus_req),
    .mem_acc_o    (mem_acc),
    .mem_addr_o   (mem_addr),
    .peri_open_o  (peri_open)
  );

  dma_word_buf #(
    .DATA_W (DATA_W)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_ns),
    .fill_i      (buf_fill),
    .fill_data_i (buf_fill_data),
    .drain_i     (buf_drain),
    .full_o      (buf_full),
    .data_o      (buf_data)
  );

  // Steering of the holding register between the two sides.
  assign to_peri       = (dir == DIR_TO_PERI);
  assign per_in_ready  = !to_peri && peri_open && !buf_full;
  assign in_fire       = per_in_valid && per_in_ready;
  assign per_out_valid = to_peri && busy && buf_full;
  assign out_fire      = per_out_valid && per_out_ready;

  assign buf_fill      = to_peri ? mem_acc   : in_fire;
  assign buf_fill_data = to_peri ? mem_rdata : per_in_data;
  assign buf_drain     = to_peri ? out_fire  : mem_acc;

  assign mem_we        = mem_acc && !to_peri;
  assign mem_re        = mem_acc && to_peri;
  assign mem_wdata     = buf_data;
  assign per_out_data  = buf_data;

  AST_GNT_DRIVE: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_we || mem_re) |-> (bus_req && bus_gnt))
    else $error("bus driven without a grant"); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (per_out_valid && !per_out_ready) |=> (per_out_valid && $stable(per_out_data)))
    else $error("offered word withdrawn or changed"); // R9

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_ns)
    !(per_in_ready && per_out_valid)) else $error("both peripheral sides active"); // R1

endmodule

// File: tb/test_dma_xfer_engine.sv
`timescale 1ns/1ps
module test_dma_xfer_engine;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int REG_W  = 16;

  typedef struct packed {
    logic       dir;
    logic       burst;
    logic [7:0] base;
    logic [7:0] cnt;
    logic [3:0] stall;
    logic       hold;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 8'h10, 8'd5, 4'd0, 1'b1},
    '{1'b1, 1'b0, 8'h20, 8'd6, 4'd2, 1'b1},
    '{1'b0, 1'b1, 8'h30, 8'd7, 4'd1, 1'b0},
    '{1'b1, 1'b1, 8'h48, 8'd8, 4'd0, 1'b1},
    '{1'b1, 1'b0, 8'h60, 8'd1, 4'd3, 1'b0},
    '{1'b0, 1'b1, 8'h70, 8'd1, 4'd2, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_idx;
  logic [REG_W-1:0]  cfg_wdata;
  logic              busy, done, done_pulse, bus_req;
  logic              bus_gnt;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we, mem_re;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              per_in_valid, per_in_ready;
  logic [DATA_W-1:0] per_in_data;
  logic              per_out_valid, per_out_ready;
  logic [DATA_W-1:0] per_out_data;

  always #2.5 clk = ~clk;

  dma_xfer_engine #(
    .ADDR_W (ADDR_W), .CNT_W (CNT_W), .DATA_W (DATA_W), .REG_W (REG_W)
  ) i_dma_xfer_engine (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_wdata (cfg_wdata),
    .busy (busy), .done (done), .done_pulse (done_pulse),
    .bus_req (bus_req), .bus_gnt (bus_gnt),
    .mem_addr (mem_addr), .mem_we (mem_we), .mem_re (mem_re),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .per_in_valid (per_in_valid), .per_in_ready (per_in_ready), .per_in_data (per_in_data),
    .per_out_valid (per_out_valid), .per_out_ready (per_out_ready), .per_out_data (per_out_data)
  );

  // Environment models
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic        hold_en = 1'b0;
  logic        src_en = 1'b0;
  logic        snk_en = 1'b0;
  logic        cur_burst = 1'b0;
  int          stall = 0;
  logic        tb_clr = 1'b0;
  logic [31:0] src_base = '0;
  int          src_idx = 0;
  int          snk_idx = 0;
  logic [31:0] mem  [0:255];
  logic [31:0] sink [0:255];
  logic        cpu_hold;

  function automatic logic [31:0] pat(input int a);
    return 32'hC0DE_0000 | 32'(a & 255);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  assign cpu_hold = hold_en && (cyc[1:0] != 2'b00);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && (bus_gnt || !cpu_hold);
  end

  assign mem_rdata     = mem[mem_addr[7:0]];
  assign per_in_valid  = src_en && ((cyc % (stall + 1)) == 0);
  assign per_in_data   = src_base + 32'(src_idx);
  assign per_out_ready = snk_en && (((cyc + 1) % (stall + 1)) == 0);

  always @(posedge clk) begin
    if (tb_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    if (tb_clr) src_idx <= 0;
    else if (per_in_valid && per_in_ready) src_idx <= src_idx + 1;
  end

  always @(posedge clk) begin
    if (tb_clr) snk_idx <= 0;
    else if (per_out_valid && per_out_ready) begin
      sink[snk_idx[7:0]] <= per_out_data;
      snk_idx <= snk_idx + 1;
    end
  end

  // Protocol monitors, sampled between edges
  int          acc_cnt = 0, bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r9 = 0;
  logic        prev_acc = 1'b0, prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((mem_we || mem_re) && !(bus_req && bus_gnt)) bad_r3 <= bad_r3 + 1;
      if (prev_acc && bus_req && !cur_burst) bad_r4 <= bad_r4 + 1;
      if (busy && cur_burst && !bus_req) bad_r5 <= bad_r5 + 1;
      if (prev_stall && (!per_out_valid || per_out_data != prev_data)) bad_r9 <= bad_r9 + 1;
      if (mem_we || mem_re) acc_cnt <= acc_cnt + 1;
      prev_acc   <= mem_we || mem_re;
      prev_stall <= per_out_valid && !per_out_ready;
      prev_data  <= per_out_data;
    end
  end

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] idx, input logic [REG_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_env();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_pulse && n < 3000) begin
      @(negedge clk); n++;
    end
    check(req, done_pulse, 32'(done_pulse), 32'd1);
    check("R6 idle+done at strobe", !busy && done, {30'd0, busy, done}, 32'd1);
    @(negedge clk);
    check("R6 strobe one cycle", !done_pulse && done, {30'd0, done_pulse, done}, 32'd1);
  endtask

  task automatic run_vec(input vec_t t, input int tag);
    int a0, b3, b4, b5, b9, mism;
    logic [31:0] expv;
    clear_env();
    src_base  = 32'h5A00_0000 | 32'(tag << 8);
    stall     = int'(t.stall);
    hold_en   = t.hold;
    cur_burst = t.burst;
    src_en    = !t.dir;
    snk_en    = t.dir;
    a0 = acc_cnt; b3 = bad_r3; b4 = bad_r4; b5 = bad_r5; b9 = bad_r9;
    reg_wr(2'd0, REG_W'(t.base));
    reg_wr(2'd1, REG_W'(t.cnt));
    reg_wr(2'd2, {13'd0, 1'b1, t.burst, t.dir});
    check("R1 start accepted, R6 done cleared", busy && !done, {30'd0, busy, done}, 32'd2);
    wait_done("R6 completion strobe");
    mism = 0;
    for (int i = 0; i < int'(t.cnt); i++) begin
      if (t.dir) expv = pat(int'(t.base) + i);
      else       expv = src_base + 32'(i);
      if ((t.dir ? sink[i] : mem[int'(t.base) + i]) !== expv) mism++;
    end
    check("R2 data at sequential addresses", mism == 0, 32'(mism), 32'd0);
    if (!t.dir)
      check("R2 word past block untouched", mem[int'(t.base) + int'(t.cnt)] == pat(int'(t.base) + int'(t.cnt)),
            mem[int'(t.base) + int'(t.cnt)], pat(int'(t.base) + int'(t.cnt)));
    check("R2 one access per word", (acc_cnt - a0) == int'(t.cnt), 32'(acc_cnt - a0), 32'(t.cnt));
    check("R9 handshake count", (t.dir ? snk_idx : src_idx) == int'(t.cnt),
          32'(t.dir ? snk_idx : src_idx), 32'(t.cnt));
    check("R3 access only with grant", bad_r3 == b3, 32'(bad_r3 - b3), 32'd0);
    if (!t.burst) check("R4 request gap after steal", bad_r4 == b4, 32'(bad_r4 - b4), 32'd0);
    else          check("R5 request held in burst", bad_r5 == b5, 32'(bad_r5 - b5), 32'd0);
    if (t.dir) check("R9 offered word held", bad_r9 == b9, 32'(bad_r9 - b9), 32'd0);
    src_en = 1'b0; snk_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 outputs idle after reset",
          {busy, done, done_pulse, bus_req, mem_we, mem_re, per_in_ready, per_out_valid} == 8'h00,
          {24'd0, busy, done, done_pulse, bus_req, mem_we, mem_re, per_in_ready, per_out_valid}, 32'd0);

    // Table of transfers
    for (int v = 0; v < 6; v++) run_vec(VECS[v], v);

    // R7: empty transfer completes at once
    clear_env();
    a0 = acc_cnt;
    reg_wr(2'd1, 16'd0);
    reg_wr(2'd2, 16'b101);
    check("R7 strobe after empty start", done_pulse && done && !busy && !bus_req,
          {28'd0, done_pulse, done, busy, bus_req}, 32'hC);
    @(negedge clk);
    check("R7 no request or access", !bus_req && !busy && (acc_cnt == a0) && !done_pulse,
          {30'd0, bus_req, busy}, 32'd0);

    // R8: writes during a transfer are ignored
    clear_env();
    src_base = 32'h7700_0000; stall = 1; hold_en = 1'b1; cur_burst = 1'b0;
    src_en = 1'b1; snk_en = 1'b0;
    reg_wr(2'd0, 16'h0040);
    reg_wr(2'd1, 16'd6);
    reg_wr(2'd2, 16'b100);
    reg_wr(2'd0, 16'h0080);
    reg_wr(2'd1, 16'd2);
    reg_wr(2'd2, 16'b111);
    check("R8 transfer still running after writes", busy, 32'(busy), 32'd1);
    wait_done("R8 first transfer completes");
    check("R8 ignored address not written", mem[8'h80] == pat(8'h80), mem[8'h80], pat(8'h80));
    check("R8 direction kept", (src_idx == 6) && (snk_idx == 0), 32'(src_idx), 32'd6);
    check("R8 last word at original range", mem[8'h45] == 32'h7700_0005, mem[8'h45], 32'h7700_0005);
    clear_env();
    src_base = 32'h7800_0000;
    reg_wr(2'd2, 16'b100);
    wait_done("R8 restart completes");
    check("R8 restart reuses address and count",
          (mem[8'h40] == 32'h7800_0000) && (mem[8'h45] == 32'h7800_0005) && (mem[8'h46] == pat(8'h46)),
          mem[8'h45], 32'h7800_0005);
    check("R8 restart leaves ignored range", mem[8'h80] == pat(8'h80), mem[8'h80], pat(8'h80));
    src_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule